// File: doc/BRIEF.md
# DRAM Mode Register and Latency Controller

This block keeps the controller's own copy of the primary DRAM mode register and derives the read timing from it. A mode-register write arrives as a 16-bit address word on a valid/ready channel. The block decodes the CAS latency code, the burst ordering and the reserved test bit, and it stores the additive latency that is supplied beside the word. It reports the resulting read latency as the sum of the two, in whole clocks only.

A write that sets the DLL-reset bit raises a single-cycle reset pulse. The bit is never held, so the request clears itself. The same write drops the lock flag and starts a lock timer. Read requests use a second valid/ready channel. A read is only taken while the DLL is locked. A read offered while unlocked is dropped and flagged with a one-cycle reject pulse. Each accepted read launches a token into a shift pipeline, and a data-valid pulse comes out exactly read-latency clocks later. Reads can therefore be accepted on every cycle. The requester may hold `rd_valid` high for as long as it likes, and each cycle with both `rd_valid` and `rd_ready` high counts as one read.

The mode channel applies back-pressure. `mrs_ready` goes low while any read token is still in the pipeline, and also in any cycle in which `rd_valid` is high. The latency therefore never changes under a read in flight, and reads win over mode writes in the same cycle. A mode write that is held off stays pending until `mrs_ready` returns.

Top module: `dram_mode_latency_ctrl`

## Requirements
- R1: After reset, cas_latency is 5, additive_latency is 0, burst_interleaved is 0, read_latency is 5, dll_locked is 0, rd_ready is 0, rd_data_valid is 0 and mrs_ready is 1.
- R2: The latency code sits in word bits [11:9]. A code c from 1 to 7 sets cas_latency to c+4, so the range is 5 to 11. Code 0 is refused: cfg_err pulses in the cycle after acceptance and every stored field stays as it was.
- R3: Word bit 3 selects the burst ordering. A value of 0 gives sequential order (burst_interleaved=0) and a value of 1 gives interleaved order (burst_interleaved=1).
- R4: A word with bit 7 set is refused as reserved test mode. cfg_err pulses, the stored fields stay unchanged, and no DLL reset takes place even if bit 8 is also set.
- R5: Each accepted, valid word also captures al_cfg into additive_latency. read_latency then equals additive_latency + cas_latency.
- R6: Word bit 8 requests a DLL reset. dll_reset_pulse is high for exactly the one cycle after acceptance and then returns to 0 by itself. A valid word with bit 8 clear leaves dll_locked as it was.
- R7: dll_locked falls on the edge that accepts a DLL-reset word. It rises exactly TDLLK clock edges after that edge.
- R8: rd_ready follows dll_locked. A read offered while unlocked is not accepted, rd_reject pulses in the next cycle, and no data-valid pulse ever follows from it.
- R9: rd_data_valid is high for one cycle exactly read_latency clock edges after the edge that accepts a read. Reads accepted on consecutive edges give pulses on consecutive cycles.
- R10: mrs_ready is 0 while a read is in flight and whenever rd_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_valid | input | 1 | Mode-register word offered |
| mrs_ready | output | 1 | Mode word can be accepted this cycle |
| mrs_addr | input | 16 | Mode-register address word |
| al_cfg | input | AL_W | Additive latency captured with each valid word |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read can be accepted (DLL locked) |
| rd_reject | output | 1 | One-cycle pulse: a read was offered while unlocked |
| rd_data_valid | output | 1 | One-cycle pulse, read_latency edges after a read is accepted |
| cas_latency | output | 4 | Stored CAS latency in clocks |
| additive_latency | output | AL_W | Stored additive latency in clocks |
| read_latency | output | RL_W | Sum of additive and CAS latency |
| burst_interleaved | output | 1 | 1 = interleaved burst order, 0 = sequential |
| dll_reset_pulse | output | 1 | Self-clearing DLL reset request |
| dll_locked | output | 1 | Lock time has elapsed since the last DLL reset |
| cfg_err | output | 1 | One-cycle pulse: mode word refused (test mode or code 0) |

## Verification
The bench builds the block with TDLLK set to 24 instead of the default 512. Each lock period is then short enough to step through edge by edge, and the rise of dll_locked can be pinned to its exact edge. AL_W keeps its default of 3, so additive latency runs from 0 to 7. With CAS codes from 1 to 7, read latencies from 5 up to 18 can be reached, which covers the full depth of the data-valid pipeline and exercises back-to-back reads at the longest setting.

// File: rtl/dmlc_pkg.sv
package dmlc_pkg;
  // mode word geometry
  localparam int MR_W       = 16;
  localparam int CL_LSB     = 9;
  localparam int CL_CODE_W  = 3;
  localparam int DLL_BIT    = 8;
  localparam int TM_BIT     = 7;
  localparam int BT_BIT     = 3;
  // latency mapping
  localparam int LAT_W      = 4;
  localparam int CL_OFFSET  = 4;
  localparam int CL_RESET   = 5;
  localparam int CL_MAX     = CL_OFFSET + (1 << CL_CODE_W) - 1;

  typedef struct packed {
    logic [LAT_W-1:0] cl;
    logic             cl_bad;
    logic             interleaved;
    logic             dll_reset;
    logic             test_mode;
  } mr0_fields_t;
endpackage

// File: rtl/dmlc_mr0_decode.sv
module dmlc_mr0_decode
  import dmlc_pkg::*;
(
  input  logic [MR_W-1:0] word,
  output mr0_fields_t     fields
);
  logic [CL_CODE_W-1:0] code;

  always_comb begin
    code               = word[CL_LSB +: CL_CODE_W];
    fields.cl          = LAT_W'(code) + LAT_W'(CL_OFFSET);
    fields.cl_bad      = (code == '0);
    fields.interleaved = word[BT_BIT];
    fields.dll_reset   = word[DLL_BIT];
    fields.test_mode   = word[TM_BIT];
  end
endmodule

// File: rtl/dmlc_dll_lock.sv
module dmlc_dll_lock #(
  parameter int TDLLK = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic locked
);
  localparam int CNT_W = $clog2(TDLLK + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      locked <= 1'b0;
    end else if (start) begin
      remain <= CNT_W'(TDLLK);
      locked <= 1'b0;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/dmlc_rd_pipe.sv
module dmlc_rd_pipe #(
  parameter int DEPTH = 18,
  parameter int RL_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [RL_W-1:0] delay,
  output logic            valid_out,
  output logic            busy
);
  logic [DEPTH:0] stage_q;
  logic [DEPTH:0] stage_d;

  always_comb begin
    stage_d = stage_q >> 1;
    if (launch) stage_d[delay] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign valid_out = stage_q[0];
  assign busy      = |stage_q[DEPTH:1];
endmodule

// File: rtl/dram_mode_latency_ctrl.sv
module dram_mode_latency_ctrl
  import dmlc_pkg::*;
#(
  parameter int TDLLK = 512,
  parameter int AL_W  = 3,
  localparam int AL_MAX = (1 << AL_W) - 1,
  localparam int RL_MAX = AL_MAX + CL_MAX,
  localparam int RL_W   = $clog2(RL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_valid,
  output logic             mrs_ready,
  input  logic [MR_W-1:0]  mrs_addr,
  input  logic [AL_W-1:0]  al_cfg,
  input  logic             rd_valid,
  output logic             rd_ready,
  output logic             rd_reject,
  output logic             rd_data_valid,
  output logic [LAT_W-1:0] cas_latency,
  output logic [AL_W-1:0]  additive_latency,
  output logic [RL_W-1:0]  read_latency,
  output logic             burst_interleaved,
  output logic             dll_reset_pulse,
  output logic             dll_locked,
  output logic             cfg_err
);
  mr0_fields_t fld;
  logic        mrs_take;
  logic        cfg_ok;
  logic        rd_take;
  logic        pipe_busy;
  logic        dll_start;

  dmlc_mr0_decode u_decode (
    .word   (mrs_addr),
    .fields (fld)
  );

  assign mrs_ready = ~pipe_busy & ~rd_valid;
  assign mrs_take  = mrs_valid & mrs_ready;
  assign cfg_ok    = mrs_take & ~fld.test_mode & ~fld.cl_bad;
  assign dll_start = cfg_ok & fld.dll_reset;
  assign rd_ready  = dll_locked;
  assign rd_take   = rd_valid & rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_latency       <= LAT_W'(CL_RESET);
      additive_latency  <= '0;
      burst_interleaved <= 1'b0;
      dll_reset_pulse   <= 1'b0;
      cfg_err           <= 1'b0;
      rd_reject         <= 1'b0;
    end else begin
      dll_reset_pulse <= dll_start;
      cfg_err         <= mrs_take & (fld.test_mode | fld.cl_bad);
      rd_reject       <= rd_valid & ~dll_locked;
      if (cfg_ok) begin
        cas_latency       <= fld.cl;
        additive_latency  <= al_cfg;
        burst_interleaved <= fld.interleaved;
      end
    end
  end

  assign read_latency = RL_W'(additive_latency) + RL_W'(cas_latency);

  dmlc_dll_lock #(.TDLLK(TDLLK)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (dll_start),
    .locked (dll_locked)
  );

  dmlc_rd_pipe #(.DEPTH(RL_MAX), .RL_W(RL_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (rd_take),
    .delay     (read_latency),
    .valid_out (rd_data_valid),
    .busy      (pipe_busy)
  );
endmodule

// File: rtl/dmlc_checker.sv
module dmlc_checker #(
  parameter int TDLLK = 512,
  parameter int AL_W  = 3,
  parameter int RL_W  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mrs_valid,
  input logic            mrs_ready,
  input logic [15:0]     mrs_addr,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic            rd_reject,
  input logic            rd_data_valid,
  input logic [3:0]      cas_latency,
  input logic [RL_W-1:0] read_latency,
  input logic            dll_reset_pulse,
  input logic            dll_locked,
  input logic            cfg_err
);
  localparam int WIN_W = $clog2(TDLLK + 2) + 1;

  logic [WIN_W-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       win <= '0;
    else if (dll_reset_pulse)         win <= WIN_W'(1);
    else if (win != '0 && win <= WIN_W'(TDLLK)) win <= win + 1'b1;
  end

  assert_cl_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cas_latency >= 4'd5 && cas_latency <= 4'd11);

  assert_err_keeps_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($stable(cas_latency) && $stable(read_latency)));

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |-> $past(mrs_valid && mrs_ready && mrs_addr[8] &&
                              !mrs_addr[7] && (mrs_addr[11:9] != 3'd0)));

  assert_lock_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |-> !dll_locked);

  assert_lock_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_locked) |-> (win == WIN_W'(TDLLK)));

  assert_reject_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reject |-> $past(rd_valid && !rd_ready));

  assert_valid_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_valid |-> dll_locked);

  assert_mrs_yields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_valid && mrs_ready) |-> !rd_valid);
endmodule

bind dram_mode_latency_ctrl dmlc_checker #(
  .TDLLK (TDLLK),
  .AL_W  (AL_W),
  .RL_W  (RL_W)
) u_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .mrs_valid       (mrs_valid),
  .mrs_ready       (mrs_ready),
  .mrs_addr        (mrs_addr),
  .rd_valid        (rd_valid),
  .rd_ready        (rd_ready),
  .rd_reject       (rd_reject),
  .rd_data_valid   (rd_data_valid),
  .cas_latency     (cas_latency),
  .read_latency    (read_latency),
  .dll_reset_pulse (dll_reset_pulse),
  .dll_locked      (dll_locked),
  .cfg_err         (cfg_err)
);

// File: tb/dram_mode_latency_ctrl_tb.sv
module dram_mode_latency_ctrl_tb;
  localparam int T_LOCK = 24;
  localparam int AW     = 3;
  localparam int RW     = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mrs_valid = 1'b0;
  logic          mrs_ready;
  logic [15:0]   mrs_addr = '0;
  logic [AW-1:0] al_cfg = '0;
  logic          rd_valid = 1'b0;
  logic          rd_ready;
  logic          rd_reject;
  logic          rd_data_valid;
  logic [3:0]    cas_latency;
  logic [AW-1:0] additive_latency;
  logic [RW-1:0] read_latency;
  logic          burst_interleaved;
  logic          dll_reset_pulse;
  logic          dll_locked;
  logic          cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dram_mode_latency_ctrl #(.TDLLK(T_LOCK), .AL_W(AW)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .mrs_valid (mrs_valid), .mrs_ready (mrs_ready), .mrs_addr (mrs_addr),
    .al_cfg (al_cfg), .rd_valid (rd_valid), .rd_ready (rd_ready),
    .rd_reject (rd_reject), .rd_data_valid (rd_data_valid),
    .cas_latency (cas_latency), .additive_latency (additive_latency),
    .read_latency (read_latency), .burst_interleaved (burst_interleaved),
    .dll_reset_pulse (dll_reset_pulse), .dll_locked (dll_locked),
    .cfg_err (cfg_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int code, input bit bt, input bit dll, input bit tm);
    logic [15:0] w;
    w       = '0;
    w[11:9] = 3'(code);
    w[8]    = dll;
    w[7]    = tm;
    w[3]    = bt;
    return w;
  endfunction

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic mrs_write(input logic [15:0] a, input int al);
    mrs_addr  = a;
    al_cfg    = AW'(al);
    mrs_valid = 1'b1;
    while (!mrs_ready) @(negedge clk);
    @(negedge clk);
    mrs_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "cas_latency", cas_latency, 5);
    check("R1", "additive_latency", additive_latency, 0);
    check("R1", "burst_interleaved", burst_interleaved, 0);
    check("R1", "read_latency", read_latency, 5);
    check("R1", "dll_locked", dll_locked, 0);
    check("R1", "rd_ready", rd_ready, 0);
    check("R1", "rd_data_valid", rd_data_valid, 0);
    check("R1", "mrs_ready", mrs_ready, 1);
  endtask

  task automatic t_reject;
    int hits = 0;
    rd_valid = 1'b1;
    #1 check("R8", "rd_ready while unlocked", rd_ready, 0);
    @(negedge clk);
    rd_valid = 1'b0;
    check("R8", "rd_reject pulse", rd_reject, 1);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (rd_data_valid) hits++;
    end
    check("R8", "data-valid after rejected read", hits, 0);
    check("R8", "rd_reject cleared", rd_reject, 0);
  endtask

  task automatic t_fields;
    mrs_write(mk(3, 1'b1, 1'b0, 1'b0), 2);
    check("R2", "cas code 3", cas_latency, 7);
    check("R3", "interleaved", burst_interleaved, 1);
    check("R5", "al captured", additive_latency, 2);
    check("R5", "read_latency 2+7", read_latency, 9);
    check("R6", "no pulse without bit 8", dll_reset_pulse, 0);
    check("R2", "no cfg_err", cfg_err, 0);
    mrs_write(mk(7, 1'b0, 1'b0, 1'b0), 0);
    check("R2", "cas code 7", cas_latency, 11);
    check("R3", "sequential", burst_interleaved, 0);
    check("R5", "read_latency 0+11", read_latency, 11);
    mrs_write(mk(0, 1'b1, 1'b0, 1'b0), 5);
    check("R2", "code 0 cfg_err", cfg_err, 1);
    check("R2", "code 0 keeps cl", cas_latency, 11);
    check("R2", "code 0 keeps burst", burst_interleaved, 0);
    check("R2", "code 0 keeps al", additive_latency, 0);
    @(negedge clk);
    check("R2", "cfg_err one cycle", cfg_err, 0);
  endtask

  task automatic t_testmode;
    mrs_write(mk(6, 1'b1, 1'b1, 1'b1), 4);
    check("R4", "test mode cfg_err", cfg_err, 1);
    check("R4", "test mode keeps cl", cas_latency, 11);
    check("R4", "test mode keeps al", additive_latency, 0);
    check("R4", "test mode no dll pulse", dll_reset_pulse, 0);
    repeat (T_LOCK + 2) @(negedge clk);
    check("R4", "test mode never locks", dll_locked, 0);
  endtask

  task automatic t_dll;
    mrs_write(mk(1, 1'b0, 1'b1, 1'b0), 1);
    check("R6", "dll_reset_pulse high", dll_reset_pulse, 1);
    check("R7", "locked low after reset", dll_locked, 0);
    check("R5", "read_latency 1+5", read_latency, 6);
    @(negedge clk);
    check("R6", "dll_reset_pulse self-clear", dll_reset_pulse, 0);
    repeat (T_LOCK - 2) @(negedge clk);
    check("R7", "locked one edge early", dll_locked, 0);
    @(negedge clk);
    check("R7", "locked at TDLLK", dll_locked, 1);
    check("R8", "rd_ready when locked", rd_ready, 1);
    mrs_write(mk(2, 1'b0, 1'b0, 1'b0), 0);
    check("R6", "plain write keeps lock", dll_locked, 1);
  endtask

  task automatic t_read(input int code, input int al);
    int rl;
    int first = -1;
    int hits  = 0;
    rl = code + 4 + al;
    mrs_write(mk(code, 1'b0, 1'b0, 1'b0), al);
    check("R5", "read_latency sum", read_latency, rl);
    rd_valid = 1'b1;
    #1 check("R10", "mrs_ready low while rd_valid", mrs_ready, 0);
    @(negedge clk);
    rd_valid = 1'b0;
    check("R10", "mrs_ready low in flight", mrs_ready, 0);
    for (int k = 1; k <= rl + 3; k++) begin
      @(negedge clk);
      if (rd_data_valid) begin
        hits++;
        if (first < 0) first = k;
      end
    end
    check("R9", "valid pulse position", first, rl);
    check("R9", "valid pulse count", hits, 1);
    check("R10", "mrs_ready back after drain", mrs_ready, 1);
  endtask

  task automatic t_back2back(input int code, input int al);
    int rl;
    int bad = 0;
    rl = code + 4 + al;
    mrs_write(mk(code, 1'b1, 1'b0, 1'b0), al);
    rd_valid = 1'b1;
    for (int s = 0; s <= rl + 5; s++) begin
      @(negedge clk);
      if (s == 2) rd_valid = 1'b0;
      if (rd_data_valid != ((s >= rl) && (s <= rl + 2))) bad++;
    end
    check("R9", "back-to-back pulse pattern mismatches", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reject();
    t_fields();
    t_testmode();
    t_dll();
    t_read(1, 0);
    t_read(3, 2);
    t_read(7, 7);
    t_back2back(2, 1);
    t_back2back(7, 7);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule